// File: doc/BRIEF.md
# Dual-Controller Width-Splitting Memory Bridge

This block joins two independent half-width memory controllers into one full-width request port. A client issues read or write requests with an address, a burst field and, for writes, a full-width data word with byte enables. Each accepted request is stored once in a command queue. The entry at the head of that queue is then offered to both controllers with the same command fields. Each controller receives only its own half of the write data.

The two controllers throttle independently, for example while one of them refreshes. The bridge therefore tracks issue separately for each side. A controller that is ready takes its half at once. The head entry stays in place until the other side has also taken its half.

Read data comes back from each controller into its own half-width queue. The client sees a full-width read word only when both queues hold data. The merged word carries the low controller's half in its low bits. Read requests reserve read-queue space when they are accepted. The controllers therefore never need a back-pressure signal on their return path.

Top module: `mem_split_bridge`

## Requirements
- R1: On a write, controller A receives bits [HALF_W-1:0] of the client data and the low HALF_W/8 byte enables. Controller B receives bits [2*HALF_W-1:HALF_W] and the high byte enables.
- R2: Both controllers are offered the same write flag, address and burst field for a given request. These fields match the request as the client presented it.
- R3: A side that accepts the head entry drops its request valid and does not see that entry again. This holds even while the other side has not yet accepted.
- R4: Requests reach each controller in client order. The head entry leaves the command queue in the cycle in which the last of the two sides has accepted it.
- R5: The client read valid is high exactly when both read-data queues are non-empty. A client read handshake removes one word from each queue.
- R6: The merged read word is {controller B word, controller A word}. Each side's words are delivered in the order in which that controller returned them.
- R7: The client ready is low whenever the command queue holds CMDQ_DEPTH entries.
- R8: A read request returns burst+1 words from each side. It is accepted only if the words already reserved and not yet delivered to the client, plus burst+1, do not exceed RDQ_DEPTH. A write is not subject to this limit.
- R9: While reset is asserted, no controller request valid, client read valid or client ready is high. Reset empties all queues and clears the issue flags and the reservation count.
- R10: A controller request that is not accepted stays valid with unchanged command fields in the next cycle. The same holds for a client read word that is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_valid | input | 1 | Client request valid |
| cl_ready | output | 1 | Client request accepted when high with cl_valid |
| cl_write | input | 1 | 1 = write, 0 = read |
| cl_addr | input | ADDR_W | Request address |
| cl_burst | input | BURST_W | Burst field; a read returns burst+1 words |
| cl_wdata | input | 2*HALF_W | Full-width write data |
| cl_be | input | HALF_W/4 | Full-width byte enables |
| cl_rvalid | output | 1 | Merged read word valid |
| cl_rready | input | 1 | Client takes the merged read word |
| cl_rdata | output | 2*HALF_W | Merged read word |
| ca_valid | output | 1 | Controller A request valid |
| ca_ready | input | 1 | Controller A accepts the request |
| ca_write | output | 1 | Controller A write flag |
| ca_addr | output | ADDR_W | Controller A address |
| ca_burst | output | BURST_W | Controller A burst field |
| ca_wdata | output | HALF_W | Low half of the write data |
| ca_be | output | HALF_W/8 | Low byte enables |
| ca_rvalid | input | 1 | Controller A returns a read word |
| ca_rdata | input | HALF_W | Controller A read word |
| cb_valid | output | 1 | Controller B request valid |
| cb_ready | input | 1 | Controller B accepts the request |
| cb_write | output | 1 | Controller B write flag |
| cb_addr | output | ADDR_W | Controller B address |
| cb_burst | output | BURST_W | Controller B burst field |
| cb_wdata | output | HALF_W | High half of the write data |
| cb_be | output | HALF_W/8 | High byte enables |
| cb_rvalid | input | 1 | Controller B returns a read word |
| cb_rdata | input | HALF_W | Controller B read word |

## Verification
The bench builds the bridge with HALF_W = 8, ADDR_W = 6, BURST_W = 2, a four-entry command queue and four-word read queues. With these values the largest read burst equals the whole read-queue depth. The read-reservation limit and the full command queue are therefore reached within a few requests, and many times over a run of 240 mixed requests. The two controller ready patterns, the return patterns and the client read-ready pattern rotate through four phases. These cover lockstep acceptance, one side leading by a cycle, one side stalled for long stretches, and a client that rarely drains. Every client-ready, request-valid and read-valid decision is compared with a count-based model in every cycle.

// File: rtl/msb_pkg.sv
package msb_pkg;
   // Number of half-width controller sides joined by the bridge.
   localparam int NUM_SIDES = 2;

   typedef enum logic {
      SIDE_LO = 1'b0,
      SIDE_HI = 1'b1
   } side_e;
endpackage

// File: rtl/msb_fifo.sv
module msb_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      initial $error("msb_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + PTR_W'(1);
         if (do_pop)  rp <= rp + PTR_W'(1);
         cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/msb_issue.sv
module msb_issue #(
   parameter int SIDES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_valid,
   input  logic [SIDES-1:0] side_ready,
   output logic [SIDES-1:0] side_valid,
   output logic             pop
);
   logic [SIDES-1:0] done, take, settled;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      assign side_valid[s] = head_valid & ~done[s];
      assign take[s]       = side_valid[s] & side_ready[s];
      assign settled[s]    = done[s] | take[s];
   end

   assign pop = head_valid & (&settled);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   done <= '0;
      else if (pop) done <= '0;
      else          done <= settled;
   end
endmodule

// File: rtl/mem_split_bridge.sv
module mem_split_bridge
   import msb_pkg::*;
#(
   parameter int HALF_W     = 32,
   parameter int ADDR_W     = 24,
   parameter int BURST_W    = 4,
   parameter int CMDQ_DEPTH = 8,
   parameter int RDQ_DEPTH  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cl_valid,
   output logic                  cl_ready,
   input  logic                  cl_write,
   input  logic [ADDR_W-1:0]     cl_addr,
   input  logic [BURST_W-1:0]    cl_burst,
   input  logic [2*HALF_W-1:0]   cl_wdata,
   input  logic [HALF_W/4-1:0]   cl_be,
   output logic                  cl_rvalid,
   input  logic                  cl_rready,
   output logic [2*HALF_W-1:0]   cl_rdata,
   output logic                  ca_valid,
   input  logic                  ca_ready,
   output logic                  ca_write,
   output logic [ADDR_W-1:0]     ca_addr,
   output logic [BURST_W-1:0]    ca_burst,
   output logic [HALF_W-1:0]     ca_wdata,
   output logic [HALF_W/8-1:0]   ca_be,
   input  logic                  ca_rvalid,
   input  logic [HALF_W-1:0]     ca_rdata,
   output logic                  cb_valid,
   input  logic                  cb_ready,
   output logic                  cb_write,
   output logic [ADDR_W-1:0]     cb_addr,
   output logic [BURST_W-1:0]    cb_burst,
   output logic [HALF_W-1:0]     cb_wdata,
   output logic [HALF_W/8-1:0]   cb_be,
   input  logic                  cb_rvalid,
   input  logic [HALF_W-1:0]     cb_rdata
);
   localparam int FULL_W  = 2 * HALF_W;
   localparam int HALF_BE = HALF_W / 8;
   localparam int FULL_BE = 2 * HALF_BE;
   localparam int BEAT_W  = BURST_W + 1;
   localparam int OCNT_W  = $clog2(RDQ_DEPTH + 1);
   localparam int SUM_W   = OCNT_W + 1;

   if (HALF_W < 8 || (HALF_W % 8) != 0) begin : g_bad_width
      initial $error("mem_split_bridge: HALF_W must be a positive multiple of 8");
   end
   if (RDQ_DEPTH < (1 << BURST_W)) begin : g_bad_rdq
      initial $error("mem_split_bridge: RDQ_DEPTH must hold the longest read burst");
   end

   typedef struct packed {
      logic               wr;
      logic [ADDR_W-1:0]  addr;
      logic [BURST_W-1:0] burst;
      logic [FULL_W-1:0]  wdata;
      logic [FULL_BE-1:0] be;
   } entry_t;
   localparam int ENTRY_W = $bits(entry_t);

   // ---------------- command queue and issue tracking ----------------
   entry_t               cq_in, head;
   logic [ENTRY_W-1:0]   cq_head_bits;
   logic                 cq_full, cq_empty, cq_push, cq_pop;
   logic [NUM_SIDES-1:0] side_rdy, side_req;

   assign cq_in   = '{wr: cl_write, addr: cl_addr, burst: cl_burst,
                      wdata: cl_wdata, be: cl_be};
   assign cq_push = cl_valid & cl_ready;
   assign head    = entry_t'(cq_head_bits);

   msb_fifo #(.WIDTH(ENTRY_W), .DEPTH(CMDQ_DEPTH)) u_cmdq (
      .clk(clk), .rst_n(rst_n),
      .push(cq_push), .din(cq_in),
      .pop(cq_pop), .dout(cq_head_bits),
      .full(cq_full), .empty(cq_empty)
   );

   assign side_rdy[SIDE_LO] = ca_ready;
   assign side_rdy[SIDE_HI] = cb_ready;

   msb_issue #(.SIDES(NUM_SIDES)) u_issue (
      .clk(clk), .rst_n(rst_n),
      .head_valid(~cq_empty & rst_n),
      .side_ready(side_rdy),
      .side_valid(side_req),
      .pop(cq_pop)
   );

   // ---------------- read reservation ----------------
   logic [BEAT_W-1:0] req_beats;
   logic [OCNT_W-1:0] out_cnt;
   logic [SUM_W-1:0]  need;
   logic              rd_room, rd_take, merge_pop;

   assign req_beats = {1'b0, cl_burst} + BEAT_W'(1);
   assign need      = SUM_W'(out_cnt) + SUM_W'(req_beats);
   assign rd_room   = (need <= SUM_W'(RDQ_DEPTH));
   assign cl_ready  = rst_n & ~cq_full & (cl_write | rd_room);
   assign rd_take   = cq_push & ~cl_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_cnt <= '0;
      else out_cnt <= out_cnt + (rd_take ? OCNT_W'(req_beats) : OCNT_W'(0))
                              - OCNT_W'(merge_pop);
   end

   // ---------------- per-side data paths ----------------
   logic [HALF_W-1:0]    wr_half [NUM_SIDES];
   logic [HALF_BE-1:0]   be_half [NUM_SIDES];
   logic [HALF_W-1:0]    rd_in   [NUM_SIDES];
   logic [HALF_W-1:0]    rq_dout [NUM_SIDES];
   logic [NUM_SIDES-1:0] rd_in_v, rq_full, rq_empty;

   assign rd_in_v[SIDE_LO] = ca_rvalid;
   assign rd_in_v[SIDE_HI] = cb_rvalid;
   assign rd_in[SIDE_LO]   = ca_rdata;
   assign rd_in[SIDE_HI]   = cb_rdata;

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      assign wr_half[s] = head.wdata[s*HALF_W +: HALF_W];
      assign be_half[s] = head.be[s*HALF_BE +: HALF_BE];

      msb_fifo #(.WIDTH(HALF_W), .DEPTH(RDQ_DEPTH)) u_rdq (
         .clk(clk), .rst_n(rst_n),
         .push(rd_in_v[s]), .din(rd_in[s]),
         .pop(merge_pop), .dout(rq_dout[s]),
         .full(rq_full[s]), .empty(rq_empty[s])
      );
   end

   assign cl_rvalid = rst_n & ~rq_empty[SIDE_LO] & ~rq_empty[SIDE_HI];
   assign merge_pop = cl_rvalid & cl_rready;
   assign cl_rdata  = {rq_dout[SIDE_HI], rq_dout[SIDE_LO]};

   assign ca_valid = side_req[SIDE_LO];
   assign ca_write = head.wr;
   assign ca_addr  = head.addr;
   assign ca_burst = head.burst;
   assign ca_wdata = wr_half[SIDE_LO];
   assign ca_be    = be_half[SIDE_LO];

   assign cb_valid = side_req[SIDE_HI];
   assign cb_write = head.wr;
   assign cb_addr  = head.addr;
   assign cb_burst = head.burst;
   assign cb_wdata = wr_half[SIDE_HI];
   assign cb_be    = be_half[SIDE_HI];
endmodule

// File: rtl/msb_checker.sv
module msb_checker #(
   parameter int HALF_W  = 32,
   parameter int ADDR_W  = 24,
   parameter int BURST_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cl_ready,
   input logic               cl_rvalid,
   input logic               cl_rready,
   input logic [2*HALF_W-1:0] cl_rdata,
   input logic               ca_valid,
   input logic               ca_ready,
   input logic               ca_write,
   input logic [ADDR_W-1:0]  ca_addr,
   input logic [BURST_W-1:0] ca_burst,
   input logic               ca_rvalid,
   input logic               cb_valid,
   input logic               cb_ready,
   input logic               cb_write,
   input logic [ADDR_W-1:0]  cb_addr,
   input logic [BURST_W-1:0] cb_burst,
   input logic               cb_rvalid,
   input logic [1:0]         rq_full,
   input logic               cq_full
);
   p_quiet_in_reset_r9: assert property (@(posedge clk)
      !rst_n |-> !ca_valid && !cb_valid && !cl_rvalid && !cl_ready);

   p_same_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ca_valid && cb_valid |->
         ca_addr == cb_addr && ca_burst == cb_burst && ca_write == cb_write);

   p_hold_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ca_valid && !ca_ready |=>
         ca_valid && $stable(ca_addr) && $stable(ca_burst) && $stable(ca_write));

   p_hold_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cb_valid && !cb_ready |=>
         cb_valid && $stable(cb_addr) && $stable(cb_burst) && $stable(cb_write));

   p_merge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cl_rvalid && !cl_rready |=> cl_rvalid && $stable(cl_rdata));

   p_one_shot_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ca_valid && ca_ready && cb_valid && !cb_ready |=> !ca_valid);

   p_one_shot_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cb_valid && cb_ready && ca_valid && !ca_ready |=> !cb_valid);

   p_no_overflow_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ca_rvalid |-> !rq_full[0]);

   p_no_overflow_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cb_rvalid |-> !rq_full[1]);

   p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cq_full |-> !cl_ready);
endmodule

bind mem_split_bridge msb_checker #(
   .HALF_W(HALF_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cl_ready(cl_ready), .cl_rvalid(cl_rvalid), .cl_rready(cl_rready),
   .cl_rdata(cl_rdata),
   .ca_valid(ca_valid), .ca_ready(ca_ready), .ca_write(ca_write),
   .ca_addr(ca_addr), .ca_burst(ca_burst), .ca_rvalid(ca_rvalid),
   .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_write(cb_write),
   .cb_addr(cb_addr), .cb_burst(cb_burst), .cb_rvalid(cb_rvalid),
   .rq_full(rq_full), .cq_full(cq_full)
);

// File: tb/sim_mem_split_bridge.sv
module sim_mem_split_bridge;
   localparam int HW   = 8;
   localparam int AW   = 6;
   localparam int BW   = 2;
   localparam int CQD  = 4;
   localparam int RQD  = 4;
   localparam int NCMD = 240;
   localparam int MAXB = NCMD * 4;
   localparam int WD   = 30000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            cl_valid, cl_ready, cl_write, cl_rvalid, cl_rready;
   logic [AW-1:0]   cl_addr;
   logic [BW-1:0]   cl_burst;
   logic [2*HW-1:0] cl_wdata, cl_rdata;
   logic [HW/4-1:0] cl_be;
   logic            ca_valid, ca_ready, ca_write, ca_rvalid;
   logic [AW-1:0]   ca_addr;
   logic [BW-1:0]   ca_burst;
   logic [HW-1:0]   ca_wdata, ca_rdata;
   logic [HW/8-1:0] ca_be;
   logic            cb_valid, cb_ready, cb_write, cb_rvalid;
   logic [AW-1:0]   cb_addr;
   logic [BW-1:0]   cb_burst;
   logic [HW-1:0]   cb_wdata, cb_rdata;
   logic [HW/8-1:0] cb_be;

   mem_split_bridge #(
      .HALF_W(HW), .ADDR_W(AW), .BURST_W(BW),
      .CMDQ_DEPTH(CQD), .RDQ_DEPTH(RQD)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_write(cl_write),
      .cl_addr(cl_addr), .cl_burst(cl_burst), .cl_wdata(cl_wdata), .cl_be(cl_be),
      .cl_rvalid(cl_rvalid), .cl_rready(cl_rready), .cl_rdata(cl_rdata),
      .ca_valid(ca_valid), .ca_ready(ca_ready), .ca_write(ca_write),
      .ca_addr(ca_addr), .ca_burst(ca_burst), .ca_wdata(ca_wdata), .ca_be(ca_be),
      .ca_rvalid(ca_rvalid), .ca_rdata(ca_rdata),
      .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_write(cb_write),
      .cb_addr(cb_addr), .cb_burst(cb_burst), .cb_wdata(cb_wdata), .cb_be(cb_be),
      .cb_rvalid(cb_rvalid), .cb_rdata(cb_rdata)
   );

   int n_run  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Request script, computed arithmetically.
   function automatic bit cw(int i);               return ((i * 5) % 7) < 4;        endfunction
   function automatic logic [AW-1:0] cad(int i);   return AW'((i * 11 + 3) % 64);   endfunction
   function automatic logic [BW-1:0] cbs(int i);   return BW'((i * 3 + i / 5) % 4); endfunction
   function automatic logic [2*HW-1:0] cwd(int i); return 16'(i * 173 + 7);        endfunction
   function automatic logic [HW/4-1:0] cbe(int i); return 2'(i % 4);               endfunction
   // Controller return data for (address, beat).
   function automatic logic [HW-1:0] fa(int a, int b); return 8'(a * 5 + b * 3 + 1); endfunction
   function automatic logic [HW-1:0] fb(int a, int b); return fa(a, b) ^ 8'hA5;     endfunction

   int ncl = 0, na = 0, nb = 0, nm = 0, rtot = 0, dA = 0, dB = 0, issA = 0, issB = 0;
   int rb_addr [MAXB];
   int rb_beat [MAXB];
   bit heldA = 0, heldB = 0;

   task automatic drive(input int c);
      int ph;
      ph = (c / 150) % 4;
      cl_valid = (ncl < NCMD);
      cl_write = cw(ncl);
      cl_addr  = cad(ncl);
      cl_burst = cbs(ncl);
      cl_wdata = cwd(ncl);
      cl_be    = cbe(ncl);
      case (ph)
         0: begin ca_ready = 1'b1;               cb_ready = 1'b1;               cl_rready = 1'b1;             end
         1: begin ca_ready = (c % 3 != 0);       cb_ready = (c % 4 < 2);        cl_rready = (c % 2 == 0);     end
         2: begin ca_ready = ((c / 7) % 2 == 0); cb_ready = ((c / 11) % 2 == 1); cl_rready = (c % 9 == 0);    end
         default: begin ca_ready = (c % 5 < 2);  cb_ready = (c % 7 != 3);       cl_rready = 1'b1;             end
      endcase
      ca_rvalid = (dA < issA) && ((c % 2 == 0) || ph == 0);
      cb_rvalid = (dB < issB) && (c % 3 != 1);
      ca_rdata  = ca_rvalid ? fa(rb_addr[dA], rb_beat[dA]) : '0;
      cb_rdata  = cb_rvalid ? fb(rb_addr[dB], rb_beat[dB]) : '0;
   endtask

   task automatic evaluate();
      int  hd, occ, outst;
      bit  exp_rdy, expA, expB, expM;
      hd    = (na < nb) ? na : nb;
      occ   = ncl - hd;
      outst = rtot - nm;
      if (cl_valid) begin
         exp_rdy = (occ < CQD) && (cw(ncl) || (outst + int'(cbs(ncl)) + 1 <= RQD));
         if (occ >= CQD)   chk(cl_ready == exp_rdy, "R7 client ready with full queue", cl_ready, exp_rdy);
         else if (!cw(ncl)) chk(cl_ready == exp_rdy, "R8 read reservation limit", cl_ready, exp_rdy);
         else              chk(cl_ready == exp_rdy, "R7 client ready for write", cl_ready, exp_rdy);
      end
      expA = (na < ncl) && (na == hd);
      expB = (nb < ncl) && (nb == hd);
      chk(ca_valid == expA, "R3 R4 side A request valid", ca_valid, expA);
      chk(cb_valid == expB, "R3 R4 side B request valid", cb_valid, expB);
      if (heldA) chk(ca_valid, "R10 side A held request", ca_valid, 1);
      if (heldB) chk(cb_valid, "R10 side B held request", cb_valid, 1);
      if (ca_valid && expA) begin
         chk({ca_write, ca_addr, ca_burst} == {cw(na), cad(na), cbs(na)},
             "R2 side A command", {ca_write, ca_addr, ca_burst}, {cw(na), cad(na), cbs(na)});
         chk({ca_wdata, ca_be} == {cwd(na)[HW-1:0], cbe(na)[0]},
             "R1 side A low data half", {ca_wdata, ca_be}, {cwd(na)[HW-1:0], cbe(na)[0]});
      end
      if (cb_valid && expB) begin
         chk({cb_write, cb_addr, cb_burst} == {cw(nb), cad(nb), cbs(nb)},
             "R2 side B command", {cb_write, cb_addr, cb_burst}, {cw(nb), cad(nb), cbs(nb)});
         chk({cb_wdata, cb_be} == {cwd(nb)[2*HW-1:HW], cbe(nb)[1]},
             "R1 side B high data half", {cb_wdata, cb_be}, {cwd(nb)[2*HW-1:HW], cbe(nb)[1]});
      end
      expM = (dA > nm) && (dB > nm);
      chk(cl_rvalid == expM, "R5 merged read valid", cl_rvalid, expM);
      if (cl_rvalid && expM)
         chk(cl_rdata == {fb(rb_addr[nm], rb_beat[nm]), fa(rb_addr[nm], rb_beat[nm])},
             "R6 merged read word", cl_rdata,
             {fb(rb_addr[nm], rb_beat[nm]), fa(rb_addr[nm], rb_beat[nm])});
      // advance the model
      heldA = ca_valid && !ca_ready;
      heldB = cb_valid && !cb_ready;
      if (ca_valid && ca_ready) begin
         if (!cw(na)) issA += int'(cbs(na)) + 1;
         na++;
      end
      if (cb_valid && cb_ready) begin
         if (!cw(nb)) issB += int'(cbs(nb)) + 1;
         nb++;
      end
      if (cl_valid && cl_ready) begin
         if (!cw(ncl)) begin
            for (int k = 0; k <= int'(cbs(ncl)); k++) begin
               rb_addr[rtot] = int'(cad(ncl));
               rb_beat[rtot] = k;
               rtot++;
            end
         end
         ncl++;
      end
      if (ca_rvalid) dA++;
      if (cb_rvalid) dB++;
      if (cl_rvalid && cl_rready) nm++;
   endtask

   initial begin
      int cyc;
      bit fin;
      ca_rvalid = 1'b0; cb_rvalid = 1'b0; ca_rdata = '0; cb_rdata = '0;
      ca_ready = 1'b1;  cb_ready = 1'b1;  cl_rready = 1'b1;
      cl_valid = 1'b1;  cl_write = 1'b1;  cl_addr = '0; cl_burst = '0;
      cl_wdata = '0;    cl_be = '0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk(!ca_valid && !cb_valid, "R9 no controller request in reset", {ca_valid, cb_valid}, 0);
         chk(!cl_ready, "R9 client ready low in reset", cl_ready, 0);
         chk(!cl_rvalid, "R9 read valid low in reset", cl_rvalid, 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      fin = 0;
      while (!fin && cyc < WD) begin
         drive(cyc);
         #1;
         evaluate();
         fin = (ncl == NCMD) && (na == NCMD) && (nb == NCMD) && (nm == rtot);
         @(negedge clk);
         cyc++;
      end
      if (!fin) chk(0, "R4 watchdog expired before all requests drained", cyc, WD);
      chk(nm == rtot, "R5 all reserved read words delivered", nm, rtot);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule